// File: doc/BRIEF.md
# Dual-Channel Pixel Line Merger

This block builds one output scan line from pixels that arrive on two input channels, A and B. Each channel is a valid/ready pixel stream. Each channel writes into its own line buffer. A line-start strobe opens a new line: it empties both buffers and starts a run of output slots, one slot per clock. The run lasts for a programmable number of slots. On each slot the block drives a data-enable and one pixel.

There are two merge modes. In odd/even mode the output takes its pixels from A and B in turn, starting with A. In left/right mode channel A supplies the left side of the line. Channel B pixels wait in their buffer until A has nothing left to give, and then channel B fills the rest of the line. The output pixel rate does not wait for the inputs. A slot whose pixel has not arrived yet is sent as an all-zero pixel. A format select picks full 24-bit or narrow 18-bit pixels.

The buffer depth is a parameter. In use it is sized to 1408 pixels per channel: half of a 2560-pixel line plus a tenth. The default is smaller so that elaboration stays light.

Top module: `pixel_line_merger`

## Requirements
- R1: While reset is asserted, out_de is 0, out_data is 0, ovf is 0, and a_ready and b_ready are both 1.
- R2: In odd/even mode (mode_lr=0), output slot k of a line (k counted from 0) carries channel A entry k/2 when k is even and channel B entry k/2 when k is odd. Entries are numbered in arrival order since the line start.
- R3: In left/right mode (mode_lr=1), each slot carries the next unread channel A entry while one is stored. The first slot that finds no unread A entry switches the line to channel B for every remaining slot.
- R4: In left/right mode, channel B pixels are stored while the left side is output. After the switch, the first slot takes B entry 0 and each later slot takes the next B entry.
- R5: A slot whose source entry has not been stored yet is output with out_de=1 and out_data=0. In odd/even mode and in the right-side phase, that source's position still advances by one.
- R6: When line_start is sampled at edge E with line_len=N, out_de is 1 after edges E+1 to E+N and 0 after edge E+N+1. When N is 0, no slot is output.
- R7: When fmt24=1, out_data carries all 24 bits of the pixel. When fmt24=0, bits 23:18 of out_data are 0 and bits 17:0 carry the pixel's low bits.
- R8: A channel's ready is 0 once that buffer holds DEPTH entries since the last line start. A pixel offered while ready is 0 is dropped, and ovf is 1 from the next edge on.
- R9: line_start empties both buffers, clears ovf, and restarts the output at slot 0, even in the middle of a line. out_de is 0 after the edge that samples line_start. A pixel accepted on that same edge becomes entry 0.
- R10: A pixel accepted at edge E can be output by a slot at edge E+1 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_lr | input | 1 | Merge mode, sampled at line start: 0 odd/even, 1 left/right |
| fmt24 | input | 1 | Output pixel width: 1 for 24-bit, 0 for 18-bit |
| line_len | input | 12 | Output slots per line |
| line_start | input | 1 | Opens a new line and empties the buffers |
| a_valid | input | 1 | Channel A pixel valid |
| a_ready | output | 1 | Channel A buffer can accept |
| a_data | input | 24 | Channel A pixel |
| b_valid | input | 1 | Channel B pixel valid |
| b_ready | output | 1 | Channel B buffer can accept |
| b_data | input | 24 | Channel B pixel |
| out_de | output | 1 | Output data enable |
| out_data | output | 24 | Output pixel |
| ovf | output | 1 | A pixel was refused since the last line start |

## Verification
All outputs are registered. The slot that a line_start at edge E opens is served at E+1. Slot k is served at E+1+k, and it sees only pixels that were accepted at E+k or earlier. ovf and the readies change one edge after the write or the refusal that causes them. The bench model advances on every rising edge, using the inputs as they stand at that edge. All comparisons are made at the falling edge, after the design's registers have settled, so each result is compared in the cycle it is due.

// File: rtl/plm_pkg.sv
package plm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ODD_A,
        ST_EVEN_B,
        ST_LEFT,
        ST_RIGHT
    } merge_state_t;
endpackage

// File: rtl/plm_lane_buffer.sv
module plm_lane_buffer #(
    parameter int PIX_W = 24,
    parameter int DEPTH = 64,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    output logic             in_ready,
    output logic [LEN_W-1:0] fill,
    input  logic [LEN_W-1:0] rd_idx,
    output logic [PIX_W-1:0] rd_data,
    output logic             refused
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

    logic [PIX_W-1:0] mem [DEPTH];
    logic             wr_en;
    logic [AW-1:0]    wr_addr;

    assign in_ready = (fill < DEPTH_L);
    assign wr_en    = in_valid && in_ready;
    assign wr_addr  = clear ? '0 : fill[AW-1:0];
    assign rd_data  = (rd_idx < DEPTH_L) ? mem[rd_idx[AW-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill    <= '0;
            refused <= 1'b0;
        end else if (clear) begin
            fill    <= wr_en ? LEN_W'(1) : '0;
            refused <= 1'b0;
        end else begin
            fill    <= fill + LEN_W'(wr_en);
            refused <= refused | (in_valid && !in_ready);
        end
    end
endmodule

// File: rtl/plm_merge_fsm.sv
module plm_merge_fsm
    import plm_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int NARROW_W = 18,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             mode_lr,
    input  logic             fmt24,
    input  logic [LEN_W-1:0] line_len,
    input  logic [LEN_W-1:0] fill_a,
    input  logic [LEN_W-1:0] fill_b,
    input  logic [PIX_W-1:0] rd_data_a,
    input  logic [PIX_W-1:0] rd_data_b,
    output logic [LEN_W-1:0] rd_idx_a,
    output logic [LEN_W-1:0] rd_idx_b,
    output logic             out_de,
    output logic [PIX_W-1:0] out_data
);
    localparam logic [PIX_W-1:0] NARROW_MASK = PIX_W'((64'd1 << NARROW_W) - 64'd1);

    merge_state_t     state, state_nx;
    logic [LEN_W-1:0] slot;
    logic             avail_a, avail_b, last_slot;
    logic             use_a, adv_a, adv_b;
    logic [PIX_W-1:0] pix, pix_fmt;

    assign avail_a   = rd_idx_a < fill_a;
    assign avail_b   = rd_idx_b < fill_b;
    assign last_slot = (slot + LEN_W'(1)) == line_len;

    // slot action for the current state
    always_comb begin
        use_a = 1'b0;
        adv_a = 1'b0;
        adv_b = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ODD_A: begin
                use_a = 1'b1;
                adv_a = 1'b1;
            end
            ST_EVEN_B: adv_b = 1'b1;
            ST_LEFT: begin
                use_a = avail_a;
                adv_a = avail_a;
                adv_b = !avail_a;
            end
            ST_RIGHT: adv_b = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        if (use_a) begin
            pix = avail_a ? rd_data_a : '0;
        end else begin
            pix = avail_b ? rd_data_b : '0;
        end
        pix_fmt = fmt24 ? pix : (pix & NARROW_MASK);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = ST_IDLE;
            ST_ODD_A:  state_nx = ST_EVEN_B;
            ST_EVEN_B: state_nx = ST_ODD_A;
            ST_LEFT:   state_nx = avail_a ? ST_LEFT : ST_RIGHT;
            ST_RIGHT:  state_nx = ST_RIGHT;
            default:   state_nx = ST_IDLE;
        endcase
        if (state != ST_IDLE && last_slot) begin
            state_nx = ST_IDLE;
        end
        if (line_start) begin
            if (line_len == '0) begin
                state_nx = ST_IDLE;
            end else begin
                state_nx = mode_lr ? ST_LEFT : ST_ODD_A;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and positions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_de   <= 1'b0;
            out_data <= '0;
            slot     <= '0;
            rd_idx_a <= '0;
            rd_idx_b <= '0;
        end else if (line_start) begin
            out_de   <= 1'b0;
            out_data <= '0;
            slot     <= '0;
            rd_idx_a <= '0;
            rd_idx_b <= '0;
        end else if (state != ST_IDLE) begin
            out_de   <= 1'b1;
            out_data <= pix_fmt;
            slot     <= slot + LEN_W'(1);
            rd_idx_a <= rd_idx_a + LEN_W'(adv_a);
            rd_idx_b <= rd_idx_b + LEN_W'(adv_b);
        end else begin
            out_de   <= 1'b0;
            out_data <= '0;
        end
    end
endmodule

// File: rtl/pixel_line_merger.sv
module pixel_line_merger #(
    parameter int PIX_W = 24,
    parameter int NARROW_W = 18,
    parameter int DEPTH = 64,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_lr,
    input  logic             fmt24,
    input  logic [LEN_W-1:0] line_len,
    input  logic             line_start,
    input  logic             a_valid,
    output logic             a_ready,
    input  logic [PIX_W-1:0] a_data,
    input  logic             b_valid,
    output logic             b_ready,
    input  logic [PIX_W-1:0] b_data,
    output logic             out_de,
    output logic [PIX_W-1:0] out_data,
    output logic             ovf
);
    localparam int NCH = 2;

    logic             ch_valid [NCH];
    logic             ch_ready [NCH];
    logic [PIX_W-1:0] ch_data  [NCH];
    logic [LEN_W-1:0] ch_fill  [NCH];
    logic [LEN_W-1:0] ch_idx   [NCH];
    logic [PIX_W-1:0] ch_rd    [NCH];
    logic             ch_ref   [NCH];

    assign ch_valid[0] = a_valid;
    assign ch_valid[1] = b_valid;
    assign ch_data[0]  = a_data;
    assign ch_data[1]  = b_data;
    assign a_ready     = ch_ready[0];
    assign b_ready     = ch_ready[1];
    assign ovf         = ch_ref[0] | ch_ref[1];

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        plm_lane_buffer #(
            .PIX_W(PIX_W),
            .DEPTH(DEPTH),
            .LEN_W(LEN_W)
        ) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (line_start),
            .in_valid(ch_valid[c]),
            .in_data (ch_data[c]),
            .in_ready(ch_ready[c]),
            .fill    (ch_fill[c]),
            .rd_idx  (ch_idx[c]),
            .rd_data (ch_rd[c]),
            .refused (ch_ref[c])
        );
    end

    plm_merge_fsm #(
        .PIX_W   (PIX_W),
        .NARROW_W(NARROW_W),
        .LEN_W   (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .mode_lr   (mode_lr),
        .fmt24     (fmt24),
        .line_len  (line_len),
        .fill_a    (ch_fill[0]),
        .fill_b    (ch_fill[1]),
        .rd_data_a (ch_rd[0]),
        .rd_data_b (ch_rd[1]),
        .rd_idx_a  (ch_idx[0]),
        .rd_idx_b  (ch_idx[1]),
        .out_de    (out_de),
        .out_data  (out_data)
    );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
    parameter int PIX_W = 24,
    parameter int NARROW_W = 18,
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fmt24,
    input logic [LEN_W-1:0] line_len,
    input logic             line_start,
    input logic             a_valid,
    input logic             a_ready,
    input logic             b_valid,
    input logic             b_ready,
    input logic             out_de,
    input logic [PIX_W-1:0] out_data,
    input logic             ovf
);
    // R8: a refused pixel raises the flag
    a_r8_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_valid && !a_ready) || (b_valid && !b_ready)) && !line_start |=> ovf);

    // R8: the flag holds until a line start
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !line_start |=> ovf);

    // R9: line start clears the flag and blanks the output for one cycle
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!out_de && !ovf));

    // R7: narrow format keeps the upper bits at zero
    a_r7_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt24 |=> (out_data[PIX_W-1:NARROW_W] == '0));

    // R6: a zero-length line outputs no slot
    a_r6_empty_line: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && line_len == '0) |=> ##1 !out_de);
endmodule

bind pixel_line_merger plm_checker #(
    .PIX_W   (PIX_W),
    .NARROW_W(NARROW_W),
    .LEN_W   (LEN_W)
) u_plm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt24     (fmt24),
    .line_len  (line_len),
    .line_start(line_start),
    .a_valid   (a_valid),
    .a_ready   (a_ready),
    .b_valid   (b_valid),
    .b_ready   (b_ready),
    .out_de    (out_de),
    .out_data  (out_data),
    .ovf       (ovf)
);

// File: tb/pixel_line_merger_test.sv
module pixel_line_merger_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_lr = 1'b0;
    logic        fmt24 = 1'b1;
    logic [11:0] line_len = '0;
    logic        line_start = 1'b0;
    logic        a_valid = 1'b0;
    logic [23:0] a_data = '0;
    logic        b_valid = 1'b0;
    logic [23:0] b_data = '0;
    logic        a_ready, b_ready, out_de, ovf;
    logic [23:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    pixel_line_merger #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .mode_lr(mode_lr), .fmt24(fmt24),
        .line_len(line_len), .line_start(line_start),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
        .out_de(out_de), .out_data(out_data), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [23:0] qa[$];
    logic [23:0] qb[$];
    bit    m_active, m_lr, m_left;
    int    m_slot, m_len, m_ra, m_rb;
    bit    exp_de, exp_ovf;
    logic [23:0] exp_data;
    string tag_de, tag_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qa.delete(); qb.delete();
            m_active = 0; m_slot = 0; m_ra = 0; m_rb = 0;
            exp_de = 0; exp_data = '0; exp_ovf = 0;
            tag_de = "R1"; tag_data = "R1";
        end else begin
            bit rdy_a, rdy_b;
            rdy_a = qa.size() < DEPTH;
            rdy_b = qb.size() < DEPTH;
            if (line_start) begin
                exp_de = 0; exp_data = '0;
                m_active = (line_len != 0);
                m_len = line_len; m_lr = mode_lr; m_left = 1;
                m_slot = 0; m_ra = 0; m_rb = 0;
                tag_de = "R9"; tag_data = "R9";
            end else if (m_active) begin
                logic [23:0] v;
                bit from_a, hit;
                if (!m_lr) begin
                    from_a = (m_slot % 2 == 0);
                    tag_data = "R2";
                end else if (m_left && m_ra < qa.size()) begin
                    from_a = 1;
                    tag_data = "R3";
                end else begin
                    m_left = 0;
                    from_a = 0;
                    tag_data = "R4";
                end
                if (from_a) begin
                    hit = m_ra < qa.size();
                    v = hit ? qa[m_ra] : '0;
                    m_ra++;
                end else begin
                    hit = m_rb < qb.size();
                    v = hit ? qb[m_rb] : '0;
                    m_rb++;
                end
                if (!hit) tag_data = "R5/R10";
                if (!fmt24) begin
                    v = v & 24'h03FFFF;
                    tag_data = {tag_data, "/R7"};
                end
                exp_de = 1; exp_data = v; tag_de = "R6";
                m_slot++;
                if (m_slot == m_len) m_active = 0;
            end else begin
                exp_de = 0; exp_data = '0; tag_de = "R6"; tag_data = "R6";
            end
            if (line_start) begin
                qa.delete(); qb.delete();
                exp_ovf = 0;
            end else begin
                exp_ovf = exp_ovf || (a_valid && !rdy_a) || (b_valid && !rdy_b);
            end
            if (a_valid && rdy_a) qa.push_back(a_data);
            if (b_valid && rdy_b) qb.push_back(b_data);
        end
    end

    task automatic check(string req, string what, logic [23:0] act, logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(tag_de, "out_de", 24'(out_de), 24'(exp_de));
            check(tag_data, "out_data", out_data, exp_data);
            check(rst_n ? "R8" : "R1", "ovf", 24'(ovf), 24'(exp_ovf));
            check(rst_n ? "R8" : "R1", "a_ready", 24'(a_ready), 24'(qa.size() < DEPTH));
            check(rst_n ? "R8" : "R1", "b_ready", 24'(b_ready), 24'(qb.size() < DEPTH));
        end
    end

    task automatic feed_a(int n, logic [23:0] base, int gap);
        for (int i = 0; i < n; i++) begin
            a_valid = 1; a_data = base + 24'(i);
            @(negedge clk);
            a_valid = 0; a_data = '0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic feed_b(int n, logic [23:0] base, int gap);
        for (int i = 0; i < n; i++) begin
            b_valid = 1; b_data = base + 24'(i);
            @(negedge clk);
            b_valid = 0; b_data = '0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic pulse_start(bit lr, bit f24, int len);
        mode_lr = lr; fmt24 = f24; line_len = 12'(len);
        line_start = 1;
        @(negedge clk);
        line_start = 0;
    endtask

    task automatic line(bit lr, bit f24, int len, int na, int nb, int ga, int gb,
                        logic [23:0] ba, logic [23:0] bb);
        fork
            pulse_start(lr, f24, len);
            feed_a(na, ba, ga);
            feed_b(nb, bb, gb);
        join
        repeat (len + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset values observed by the per-cycle compare
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: odd/even, continuous feed
        line(0, 1, 16, 8, 8, 0, 0, 24'hA10000, 24'hB10000);
        // R5: odd/even with gaps, zero fill
        line(0, 1, 12, 6, 6, 2, 1, 24'hA20000, 24'hB20000);
        // R3 / R4: left/right, continuous
        line(1, 1, 20, 10, 10, 0, 0, 24'hA30000, 24'hB30000);
        // R3 / R4: left/right, A gaps cause an early switch
        line(1, 1, 14, 7, 7, 1, 0, 24'hA40000, 24'hB40000);
        // R4 / R5: left/right, B slower than output
        line(1, 1, 16, 4, 10, 0, 2, 24'hA50000, 24'hB50000);
        // R7: narrow format
        line(0, 0, 8, 4, 4, 0, 0, 24'hFC0000, 24'hFFFFFF);
        line(1, 0, 8, 4, 4, 0, 0, 24'hEC1234, 24'hDC5678);
        // R6: length shorter than data
        line(0, 1, 6, 8, 8, 0, 0, 24'hA60000, 24'hB60000);
        // R6: zero length
        line(1, 1, 0, 3, 3, 0, 0, 24'hA70000, 24'hB70000);
        // R8: fill channel A beyond depth with no line running
        feed_a(DEPTH + 5, 24'h0A0000, 0);
        feed_b(DEPTH, 24'h0B0000, 0);
        repeat (3) @(negedge clk);
        // R9: start clears the buffers and the flag
        line(0, 1, 10, 5, 5, 0, 0, 24'hA80000, 24'hB80000);
        // R9: restart in the middle of a line
        fork
            pulse_start(1, 1, 30);
            feed_a(8, 24'hA90000, 0);
            feed_b(8, 24'hB90000, 0);
        join
        repeat (3) @(negedge clk);
        line(0, 1, 10, 5, 5, 0, 0, 24'hAA0000, 24'hBA0000);
        // R10: a pixel written one edge before its slot
        line(0, 1, 4, 2, 2, 0, 0, 24'hAB0000, 24'hBB0000);
        finish_run();
    end
endmodule